// File: doc/BRIEF.md
# MSI Vector Status Aggregator

This block keeps the per-vector status of message-signalled interrupts that have already been decoded into a bank number and a bit number. Each bank holds a status word and an enable word. A vector whose status and enable bits are both 1 counts as pending. The live OR of all pending vectors drives a sticky summary bit, and that summary bit drives a level interrupt line to the CPU.

The summary bit does not fall when the pending vectors drain. Software clears it with an explicit write. It is set again only when the live OR goes from zero to nonzero. If software clears the summary while any vector is still pending, later vector events do not raise the CPU interrupt until the vectors have all been seen at zero together.

Each bank has its own event port. An event port is a valid/ready pair plus a vector index, and ready is always high: an event is taken in every cycle its valid is high, with no back-pressure. Software reaches the registers through a plain port with a write strobe, an address and write data. Read data is combinational from the address.

Register addresses:
- Bank b status is at address 2b. Reads return the status word. Writes are write-one-to-clear.
- Bank b enable is at address 2b+1. It is a plain read/write register.
- The summary register is at address 2×NUM_BANKS. Bit 0 reads the sticky bit and bit 1 reads the live OR. Writing 1 to bit 0 clears the sticky bit.

Top module: `msi_status_aggregator`

## Requirements
- R1: After reset, every status word, every enable word and the summary register read 0, and `irq` is low.
- R2: An accepted event on bank b with index v sets bit v of the status word at address 2b, and the bit reads back from the next cycle on.
- R3: A write to address 2b clears exactly the status bits written as 1. Status bits written as 0 are unchanged, and writing 1 to a bit that is already 0 sets nothing.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set. Other bits in that write are still cleared.
- R5: The enable word at address 2b+1 reads back what was written. A status bit counts toward the live OR only while its enable bit is 1.
- R6: The sticky bit becomes 1 in the cycle after the live OR goes from 0 to 1, and `irq` equals the sticky bit.
- R7: The sticky bit stays 1 after all status bits are cleared. It falls only when software writes 1 to bit 0 of the summary register.
- R8: If the live OR is still 1 when the sticky bit is cleared, later events leave the sticky bit and `irq` at 0. Only after the live OR has been 0 does a new event raise them again.
- R9: A read of the summary register returns the sticky bit in bit 0, the live OR in bit 1, and zeros in all other bits.
- R10: `evt_ready` is all ones. Events arriving on several banks in the same cycle are all recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | NUM_BANKS | Per-bank event valid |
| evt_ready | output | NUM_BANKS | Per-bank event ready, always 1 |
| evt_vec | input | NUM_BANKS*VEC_W | Per-bank vector index, bank b in bits [b*VEC_W +: VEC_W] |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | VEC_PER_BANK | Register write data |
| reg_rdata | output | VEC_PER_BANK | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
The hardest situation to reach is the missed re-arm. In that state the sticky bit is 0, a vector is still pending, and a new event arrives without raising `irq`. To reach it, the bench raises one vector and clears the summary while that vector is still set. It then fires an event in another bank and checks that `irq` stays low. Next it drains both vectors one at a time and checks that a later event raises `irq` again. A full sweep of all 256 vectors checks the timing of the set, the interrupt, the status clear and the summary clear for every bank and bit position.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  // Address of the status word of bank b
  function automatic int unsigned stat_addr(int unsigned b);
    return 2 * b;
  endfunction

  // Address of the enable word of bank b
  function automatic int unsigned en_addr(int unsigned b);
    return 2 * b + 1;
  endfunction

  // Address of the summary register
  function automatic int unsigned top_addr(int unsigned nbanks);
    return 2 * nbanks;
  endfunction
endpackage

// File: rtl/msi_vec_bank.sv
module msi_vec_bank #(
  parameter int VEC   = 32,
  parameter int VEC_W = $clog2(VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [VEC_W-1:0] evt_vec,
  input  logic             wr_stat,
  input  logic             wr_en,
  input  logic [VEC-1:0]   wdata,
  output logic [VEC-1:0]   stat_o,
  output logic [VEC-1:0]   en_o,
  output logic             pend_o
);
  logic [VEC-1:0] stat_q, en_q, set_mask, clr_mask;

  // One-hot mask of the bit named by an accepted event
  always_comb begin
    set_mask = '0;
    for (int i = 0; i < VEC; i++)
      if (evt_valid && (evt_vec == VEC_W'(i))) set_mask[i] = 1'b1;
  end

  assign clr_mask = wr_stat ? wdata : '0;

  // The event mask is ORed in after the clear, so a set wins over a clear on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | set_mask;
      if (wr_en) en_q <= wdata;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);

  AST_EVT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> stat_q[$past(evt_vec)]); // R2
  AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !evt_valid) |=> ((stat_q & $past(wdata)) == '0)); // R3
  AST_CLR_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & ~$past(wdata)) == ($past(stat_q) & ~$past(wdata)) | ($past(set_mask) & ~$past(wdata)))); // R3
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(wdata))); // R5
endmodule

// File: rtl/msi_top_latch.sv
module msi_top_latch #(
  parameter int NUM_BANKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] pend,
  input  logic                 clr,
  output logic                 agg_o,
  output logic                 sticky_o
);
  logic agg, agg_q, sticky_q, rise;

  assign agg  = |pend;
  assign rise = agg && !agg_q;

  // On the same edge, a rising live OR wins over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      agg_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      agg_q <= agg;
      if (rise)     sticky_q <= 1'b1;
      else if (clr) sticky_q <= 1'b0;
    end
  end

  assign agg_o    = agg;
  assign sticky_o = sticky_q;

  AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (agg && !agg_q) |=> sticky_q); // R6
  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr) |=> sticky_q); // R7
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_q && agg_q && agg) |=> !sticky_q); // R8
endmodule

// File: rtl/msi_status_aggregator.sv
module msi_status_aggregator
  import msi_agg_pkg::*;
#(
  parameter int NUM_BANKS    = 8,
  parameter int VEC_PER_BANK = 32,
  parameter int VEC_W        = $clog2(VEC_PER_BANK),
  parameter int ADDR_W       = $clog2(2 * NUM_BANKS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       evt_valid,
  output logic [NUM_BANKS-1:0]       evt_ready,
  input  logic [NUM_BANKS*VEC_W-1:0] evt_vec,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [VEC_PER_BANK-1:0]    reg_wdata,
  output logic [VEC_PER_BANK-1:0]    reg_rdata,
  output logic                       irq
);
  localparam logic [ADDR_W-1:0] TOP_A = ADDR_W'(top_addr(NUM_BANKS));

  logic [NUM_BANKS-1:0]    pend;
  logic [VEC_PER_BANK-1:0] stat_w [NUM_BANKS];
  logic [VEC_PER_BANK-1:0] en_w   [NUM_BANKS];
  logic                    agg, sticky, top_clr;

  // The block never back-pressures an event port
  assign evt_ready = '1;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_s, wr_e;
    assign wr_s = reg_wr && (reg_addr == ADDR_W'(stat_addr(b)));
    assign wr_e = reg_wr && (reg_addr == ADDR_W'(en_addr(b)));
    msi_vec_bank #(.VEC(VEC_PER_BANK), .VEC_W(VEC_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_valid(evt_valid[b]),
      .evt_vec  (evt_vec[b*VEC_W +: VEC_W]),
      .wr_stat  (wr_s),
      .wr_en    (wr_e),
      .wdata    (reg_wdata),
      .stat_o   (stat_w[b]),
      .en_o     (en_w[b]),
      .pend_o   (pend[b])
    );
  end

  assign top_clr = reg_wr && (reg_addr == TOP_A) && reg_wdata[0];

  msi_top_latch #(.NUM_BANKS(NUM_BANKS)) i_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .clr     (top_clr),
    .agg_o   (agg),
    .sticky_o(sticky)
  );

  // Combinational read mux: bit 0 of the address picks status or enable
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == TOP_A) begin
      reg_rdata[0] = sticky;
      reg_rdata[1] = agg;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (reg_addr == ADDR_W'(stat_addr(b))) reg_rdata = stat_w[b];
        if (reg_addr == ADDR_W'(en_addr(b)))   reg_rdata = en_w[b];
      end
    end
  end

  assign irq = sticky;

  AST_IRQ_FOLLOWS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(agg) && !$past(irq)) |=> irq); // R6
  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (top_clr && irq && !(agg && !$past(agg))) |=> !irq); // R7
endmodule

// File: tb/test_msi_status_aggregator.sv
module test_msi_status_aggregator;
  localparam int NB = 8;
  localparam int NV = 32;
  localparam int VW = 5;
  localparam int AW = 5;
  localparam int TOPA = 2 * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] evt_valid = '0;
  logic [NB-1:0] evt_ready;
  logic [NB*VW-1:0] evt_vec = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [NV-1:0] reg_wdata = '0;
  logic [NV-1:0] reg_rdata;
  logic irq;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  msi_status_aggregator i_msi_status_aggregator (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_vec(evt_vec), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(string req, logic [NV-1:0] got, logic [NV-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [NV-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [NV-1:0] d);
    reg_addr = AW'(a);
    #1;
    d = reg_rdata;
  endtask

  task automatic fire(int b, int v);
    @(negedge clk);
    evt_valid[b] = 1'b1; evt_vec[b*VW +: VW] = VW'(v);
    @(negedge clk);
    evt_valid = '0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NV-1:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: every register reads zero after reset
    for (int a = 0; a <= TOPA; a++) begin
      rd(a, d); check("R1 reg", d, '0);
    end
    check("R1 irq", NV'(irq), '0);
    check("R10 ready", NV'(evt_ready), NV'({NB{1'b1}}));

    // R5: a disabled vector records status but does not interrupt
    wr(9, 32'hA5A5_0F0F);
    rd(9, d); check("R5 enable readback", d, 32'hA5A5_0F0F);
    fire(4, 4); tick();
    rd(8, d); check("R5 status recorded", d, 32'h10);
    rd(TOPA, d); check("R5 masked top", d, 0);
    check("R5 masked irq", NV'(irq), 0);
    wr(9, 32'hA5A5_0F1F); tick();
    rd(TOPA, d); check("R5 enable raises", d, 3);
    wr(8, 32'h10); wr(TOPA, 1);
    rd(TOPA, d); check("R5 cleanup", d, 0);

    for (int b = 0; b < NB; b++) wr(2*b+1, '1);

    // R2 R6 R7 R9: sweep every bank and vector
    for (int b = 0; b < NB; b++) begin
      for (int v = 0; v < NV; v++) begin
        fire(b, v);
        rd(2*b, d); check("R2 status set", d, NV'(1) << v);
        rd(TOPA, d); check("R9 live before sticky", d, 2);
        tick();
        rd(TOPA, d); check("R6 sticky set", d, 3);
        check("R6 irq", NV'(irq), 1);
        wr(2*b, NV'(1) << v);
        rd(2*b, d); check("R3 cleared", d, 0);
        rd(TOPA, d); check("R7 sticky holds", d, 1);
        check("R7 irq holds", NV'(irq), 1);
        wr(TOPA, 1);
        rd(TOPA, d); check("R7 top clear", d, 0);
        check("R7 irq low", NV'(irq), 0);
      end
    end

    // R3: a partial write-one-to-clear leaves the other bits alone
    fire(3, 1); fire(3, 2); fire(3, 9);
    wr(6, (NV'(1) << 2) | (NV'(1) << 20));
    rd(6, d); check("R3 partial", d, (NV'(1) << 1) | (NV'(1) << 9));
    wr(6, '1); tick(); wr(TOPA, 1);

    // R4: an event and a clear on the same bit in the same cycle leave it set
    fire(0, 6); fire(0, 5);
    @(negedge clk);
    evt_valid[0] = 1'b1; evt_vec[0 +: VW] = 5'd5;
    reg_wr = 1'b1; reg_addr = 0; reg_wdata = 32'h60;
    @(negedge clk);
    evt_valid = '0; reg_wr = 1'b0;
    rd(0, d); check("R4 set wins", d, 32'h20);
    wr(0, '1); tick(); wr(TOPA, 1);

    // R8: clearing the summary while a vector is pending stops the re-arm
    fire(0, 3); tick();
    wr(TOPA, 1);
    fire(1, 7); tick(); tick();
    rd(TOPA, d); check("R8 no re-arm", d, 2);
    check("R8 irq stays low", NV'(irq), 0);
    wr(0, NV'(1) << 3); tick();
    rd(TOPA, d); check("R8 still pending", d, 2);
    wr(2, NV'(1) << 7); tick();
    rd(TOPA, d); check("R8 drained", d, 0);
    fire(2, 0); tick();
    rd(TOPA, d); check("R8 re-armed", d, 3);
    check("R8 irq re-armed", NV'(irq), 1);
    wr(4, '1); tick(); wr(TOPA, 1);

    // R10: events on every bank in the same cycle
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      evt_valid[b] = 1'b1; evt_vec[b*VW +: VW] = VW'(b*3);
    end
    @(negedge clk);
    evt_valid = '0;
    for (int b = 0; b < NB; b++) begin
      rd(2*b, d); check("R10 parallel", d, NV'(1) << (b*3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule